// File: doc/BRIEF.md
# Multi-Channel Pulse-Width Generator with Period-Aligned Reconfiguration

The block drives a set of independent pulse-width outputs from a single clock. Software programs each channel through a write-only register port. A channel has a duty word, which is the number of counter ticks the output spends in its active state, and a period word. The period word holds the period length in ticks, a drive code for the active portion, a drive code for the inactive portion and a prescaler select. The prescaler select picks how many clock cycles make up one counter tick.

Programming is done in two phases. A duty write only stages the new duty value. A period write stages its own fields and arms a commit. The commit copies both staged values into the working configuration when the running period ends, so a period that has already started always completes with the settings it began with. On a disabled channel the commit takes effect on the next clock. Channels are switched on and off through separate set and clear addresses, where each written 1 selects the channel at that bit index. The outputs are a level and an output-enable per channel, so a drive code can make a pin float.

Top module: `pwm_multi`

## Requirements
- R1: After reset every channel is disabled, both drive codes are 0, and every `pwm_oe` and `pwm_out` bit is 0.
- R2: Writing to address 0x04 enables each channel whose bit is 1 in `wr_data`. Writing to address 0x08 disables each such channel. Bits that are 0 leave their channel unchanged.
- R3: A disabled channel holds its tick counter at zero and drives its committed inactive code. A period write to a disabled channel commits on the next clock.
- R4: With duty D, period P (D < P) and prescaler ratio R, an enabled channel is active for D·R cycles and then inactive for (P−D)·R cycles, and this repeats every P·R cycles.
- R5: A duty write alone changes nothing at the outputs. The value stays staged until a period write commits it.
- R6: A period write commits the staged duty and period fields together at the end of the running period. The period in progress completes with the old settings.
- R7: When duty ≥ period (period ≥ 1), the output stays in the active state for the whole period.
- R8: Drive codes: 0 floats the pin (`pwm_oe`=0), 1 drives high, 2 drives low, 3 drives high.
- R9: Prescaler select codes 0 to 7 give ratios 1, 2, 4, 8, 16, 64, 256 and 1024 clock cycles per tick.
- R10: Channel n has its registers at base 0x20·(n+1). The duty word is at base+0x0, with the duty in bits [31:16]. The period word is at base+0x4, with the period in [15:0], the active code in [17:16], the inactive code in [19:18] and the prescaler select in [22:20].
- R11: Enabling a channel restarts its counter from zero with the committed settings, so the active portion begins on the first cycle after the enable write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register byte address |
| wr_data | input | 32 | Register write data |
| pwm_out | output | NUM_CH | Pin level per channel |
| pwm_oe | output | NUM_CH | Pin output-enable per channel |

## Verification
The hardest case to reach is a configuration write that lands partway through a running period. The bench must show that the old period finishes intact and that the new one starts exactly at the boundary. It must also show that a duty write with no period write after it leaves several later periods unchanged. The stimulus synchronises to the output itself. The driver waits until the scoreboard has taken every expected pulse, which happens just after an observed rising edge. It then issues the writes inside that period and queues the old shape for the period in progress and the new shape for the periods after it. Long-ratio prescaling and the always-active case are measured as run lengths at the pins.

// File: rtl/pwm_multi_pkg.sv
// Package: shared widths, register field positions, channel configuration
// type and the small decode functions used by the channel logic.
package pwm_multi_pkg;

    localparam int DATA_W    = 32;
    localparam int CNT_W     = 16;
    localparam int SEL_W     = 3;
    localparam int CODE_W    = 2;
    localparam int PSC_W     = 10;

    localparam int DUTY_LSB  = 16;
    localparam int PER_LSB   = 0;
    localparam int ACT_LSB   = 16;
    localparam int INACT_LSB = 18;
    localparam int DIV_LSB   = 20;

    typedef logic [CODE_W-1:0] drive_code_t;

    typedef struct packed {
        logic [CNT_W-1:0] duty;
        logic [CNT_W-1:0] period;
        drive_code_t      act;
        drive_code_t      inact;
        logic [SEL_W-1:0] div_sel;
    } chan_cfg_t;

    // Terminal count of the prescaler (ratio minus one) for a select code.
    function automatic logic [PSC_W-1:0] psc_limit(input logic [SEL_W-1:0] sel);
        case (sel)
            3'd0:    return PSC_W'(0);
            3'd1:    return PSC_W'(1);
            3'd2:    return PSC_W'(3);
            3'd3:    return PSC_W'(7);
            3'd4:    return PSC_W'(15);
            3'd5:    return PSC_W'(63);
            3'd6:    return PSC_W'(255);
            default: return PSC_W'(1023);
        endcase
    endfunction

    // Pin drive for a code, returned as {output_enable, level}.
    function automatic logic [1:0] drive_decode(input drive_code_t code);
        case (code)
            2'd0:    return 2'b00;
            2'd1:    return 2'b11;
            2'd2:    return 2'b10;
            default: return 2'b11;
        endcase
    endfunction

endpackage

// File: rtl/pwm_regfile.sv
// Register decode. Holds the channel enable mask, which is changed through
// the set and clear addresses, and produces one-cycle duty and period write
// strobes per channel. Assumes one write per cycle and byte addresses where
// channel n occupies a 0x20 window starting at 0x20*(n+1).
module pwm_regfile #(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [NUM_CH-1:0] mask_bits,
    output logic [NUM_CH-1:0] ch_en,
    output logic [NUM_CH-1:0] duty_wr,
    output logic [NUM_CH-1:0] period_wr
);
    localparam int STRIDE     = 32;
    localparam int SET_OFS    = 4;
    localparam int CLR_OFS    = 8;
    localparam int DUTY_OFS   = 0;
    localparam int PERIOD_OFS = 4;

    logic set_hit;
    logic clr_hit;

    assign set_hit = wr_en && (wr_addr == ADDR_W'(SET_OFS));
    assign clr_hit = wr_en && (wr_addr == ADDR_W'(CLR_OFS));

    // Enable mask: set and clear aliases touch only the bits written as 1.
    always_ff @(posedge clk) begin
        if (!rst_n)       ch_en <= '0;
        else if (set_hit) ch_en <= ch_en | mask_bits;
        else if (clr_hit) ch_en <= ch_en & ~mask_bits;
    end

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_dec
        localparam int BASE = (ch + 1) * STRIDE;
        assign duty_wr[ch]   = wr_en && (wr_addr == ADDR_W'(BASE + DUTY_OFS));
        assign period_wr[ch] = wr_en && (wr_addr == ADDR_W'(BASE + PERIOD_OFS));

        p_set_enables_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (set_hit && mask_bits[ch]) |=> ch_en[ch]);
        p_clr_disables_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_hit && mask_bits[ch]) |=> !ch_en[ch]);
        p_mask_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (!set_hit && !clr_hit) |=> $stable(ch_en[ch]));
    end

endmodule

// File: rtl/pwm_prescaler.sv
// Per-channel clock divider. While run is high it issues one tick every
// ratio cycles, where the ratio comes from the select code. While run is low
// it rests at zero. Assumes the select only changes on a tick or while idle.
module pwm_prescaler
    import pwm_multi_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SEL_W-1:0] div_sel,
    output logic             tick
);
    logic [PSC_W-1:0] psc_cnt;
    logic [PSC_W-1:0] lim;

    assign lim  = psc_limit(div_sel);
    assign tick = run && (psc_cnt == lim);

    // Divider count: restarts after each tick and whenever the channel is off.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) psc_cnt <= '0;
        else if (tick)      psc_cnt <= '0;
        else                psc_cnt <= psc_cnt + PSC_W'(1);
    end

    p_tick_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && lim != '0) |=> (!tick || lim == '0));
    p_cnt_bounded_r9: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (psc_cnt <= lim));

endmodule

// File: rtl/pwm_channel.sv
// One output channel. It stages duty and period writes, commits them at a
// period boundary (or at once while disabled), runs the tick counter and
// decodes the committed drive codes onto the pin.
// Assumes the strobes last one cycle and the data is valid with them.
module pwm_channel
    import pwm_multi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              duty_wr,
    input  logic              period_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic              pin_level,
    output logic              pin_oe
);
    chan_cfg_t        stg;
    chan_cfg_t        cfg;
    logic             pending;
    logic [CNT_W-1:0] cnt;
    logic             tick;
    logic             wrap;
    logic             boundary;
    logic             commit;
    logic             active;
    drive_code_t      code;

    pwm_prescaler u_psc (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (en),
        .div_sel (cfg.div_sel),
        .tick    (tick)
    );

    assign wrap     = ({1'b0, cnt} + (CNT_W + 1)'(1)) >= {1'b0, cfg.period};
    assign boundary = tick && wrap;
    assign commit   = pending && (!en || boundary);

    // Staging registers: duty and period words land here first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg <= '0;
        end else begin
            if (duty_wr)
                stg.duty <= wdata[DUTY_LSB +: CNT_W];
            if (period_wr) begin
                stg.period  <= wdata[PER_LSB +: CNT_W];
                stg.act     <= wdata[ACT_LSB +: CODE_W];
                stg.inact   <= wdata[INACT_LSB +: CODE_W];
                stg.div_sel <= wdata[DIV_LSB +: SEL_W];
            end
        end
    end

    // Arm flag: set by a period write, cleared when the commit happens.
    always_ff @(posedge clk) begin
        if (!rst_n)         pending <= 1'b0;
        else if (period_wr) pending <= 1'b1;
        else if (commit)    pending <= 1'b0;
    end

    // Working configuration: copied from staging only when committing.
    always_ff @(posedge clk) begin
        if (!rst_n)      cfg <= '0;
        else if (commit) cfg <= stg;
    end

    // Tick counter: counts 0..period-1, held at zero while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) cnt <= '0;
        else if (tick)     cnt <= wrap ? '0 : cnt + CNT_W'(1);
    end

    // Pin decode: the active code while below duty, otherwise the inactive code.
    always_comb begin
        active = en && (cnt < cfg.duty);
        code   = active ? cfg.act : cfg.inact;
        {pin_oe, pin_level} = drive_decode(code);
    end

    p_commit_needs_arm_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !pending |=> $stable(cfg));
    p_commit_at_boundary_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !boundary) |=> $stable(cfg));
    p_cnt_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && cfg.period > CNT_W'(1)) |-> (cnt < cfg.period));
    p_full_duty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (en && cfg.period != '0 && cfg.duty >= cfg.period && cfg.act == 2'd3)
        |-> (pin_oe && pin_level));
    p_idle_counter_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (cnt == '0));

endmodule

// File: rtl/pwm_multi.sv
// Top level: the register decode plus NUM_CH channel instances.
// Assumes ADDR_W is wide enough for 0x20*(NUM_CH+1) and NUM_CH <= 32.
module pwm_multi
    import pwm_multi_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [NUM_CH-1:0] pwm_out,
    output logic [NUM_CH-1:0] pwm_oe
);
    logic [NUM_CH-1:0] ch_en;
    logic [NUM_CH-1:0] duty_wr;
    logic [NUM_CH-1:0] period_wr;

    pwm_regfile #(
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .mask_bits (wr_data[NUM_CH-1:0]),
        .ch_en     (ch_en),
        .duty_wr   (duty_wr),
        .period_wr (period_wr)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        pwm_channel u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .en        (ch_en[i]),
            .duty_wr   (duty_wr[i]),
            .period_wr (period_wr[i]),
            .wdata     (wr_data),
            .pin_level (pwm_out[i]),
            .pin_oe    (pwm_oe[i])
        );
    end

endmodule

// File: tb/pwm_multi_test.sv
`timescale 1ns/1ps
module pwm_multi_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0] pwm_out;
    logic [3:0] pwm_oe;

    int n_checks = 0;
    int n_errs   = 0;

    typedef struct { int hi; int per; } pulse_t;
    pulse_t exp_q[$];
    bit mon_active = 1'b0;
    bit prev_s = 1'b0;
    bit seen = 1'b0;
    int hi_cnt = 0;
    int tot_cnt = 0;

    pwm_multi uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pwm_out(pwm_out), .pwm_oe(pwm_oe)
    );

    always #4 clk = ~clk;

    task automatic chk(input string req, input string what, input int actual, input int expected);
        n_checks++;
        if (actual != expected) begin
            n_errs++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, actual, expected);
        end
    endtask

    task automatic finish_sim();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    endtask

    task automatic bus_write(input int addr, input int data);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 8'(addr); wr_data = 32'(data);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic int duty_addr(input int ch);   return (ch + 1) * 32;     endfunction
    function automatic int period_addr(input int ch); return (ch + 1) * 32 + 4; endfunction
    function automatic int per_word(input int p, input int act, input int inact, input int dv);
        return (dv << 20) | (inact << 18) | (act << 16) | p;
    endfunction

    task automatic push(input int hi, input int per, input int n);
        pulse_t e;
        e.hi = hi; e.per = per;
        for (int k = 0; k < n; k++) exp_q.push_back(e);
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    task automatic run_len(input int ch, input bit level, input int limit, output int n);
        n = 0;
        while (pwm_out[ch] == level && pwm_oe[ch] && n < limit) begin
            n++;
            @(negedge clk);
        end
    endtask

    // Scoreboard monitor: measures channel 0 between rising edges, compares with queue.
    initial begin
        forever begin
            @(negedge clk);
            begin
                bit s;
                s = pwm_out[0] && pwm_oe[0];
                if (!mon_active) seen = 1'b0;
                else begin
                    if (s && !prev_s) begin
                        if (seen) begin
                            if (exp_q.size() == 0) chk("R4,R6", "unexpected period", tot_cnt, 0);
                            else begin
                                pulse_t e;
                                e = exp_q.pop_front();
                                chk("R4,R6", "active cycles", hi_cnt, e.hi);
                                chk("R4,R6", "period cycles", tot_cnt, e.per);
                            end
                        end
                        seen = 1'b1; hi_cnt = 0; tot_cnt = 0;
                    end
                    if (seen) begin
                        tot_cnt++;
                        if (s) hi_cnt++;
                    end
                end
                prev_s = s;
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(8 * 150000);
        n_checks++; n_errs++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_sim();
    end

    initial begin
        int n;
        int bad;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "oe after reset", int'(pwm_oe), 0);
        chk("R1", "out after reset", int'(pwm_out), 0);

        // R10 R3: program channel 0 while disabled, commit is immediate
        bus_write(duty_addr(0), 3 << 16);
        bus_write(period_addr(0), per_word(8, 3, 2, 0));
        @(negedge clk);
        chk("R3", "disabled ch0 oe", int'(pwm_oe[0]), 1);
        chk("R3", "disabled ch0 level", int'(pwm_out[0]), 0);

        // R4 steady pulses, R5 duty-only write, R6 boundary commit
        mon_active = 1'b1;
        push(3, 8, 3);
        bus_write(4, 1);
        drain();
        push(3, 8, 2);
        bus_write(duty_addr(0), 5 << 16);     // R5: staged only
        drain();
        push(3, 8, 1);                         // R6: period in progress keeps old shape
        bus_write(period_addr(0), per_word(8, 3, 2, 1));
        push(10, 16, 3);
        drain();
        mon_active = 1'b0;

        // R2 clear alias, R3 inactive drive while disabled
        bus_write(8, 1);
        bad = 0;
        for (int k = 0; k < 20; k++) begin
            if (pwm_out[0] !== 1'b0 || pwm_oe[0] !== 1'b1) bad++;
            @(negedge clk);
        end
        chk("R2,R3", "cycles not inactive after clear", bad, 0);

        // R11 restart from zero with committed settings
        bus_write(4, 1);
        run_len(0, 1'b1, 100, n);
        chk("R11", "first active run", n, 10);
        run_len(0, 1'b0, 100, n);
        chk("R11", "first inactive run", n, 6);
        bus_write(8, 1);

        // R7 duty above period on channel 1; R2 zero bits leave ch0 off
        bus_write(duty_addr(1), 20 << 16);
        bus_write(period_addr(1), per_word(6, 3, 2, 0));
        bus_write(4, 2);
        bad = 0;
        for (int k = 0; k < 30; k++) begin
            if (pwm_out[1] !== 1'b1 || pwm_oe[1] !== 1'b1) bad++;
            @(negedge clk);
        end
        chk("R7", "cycles not active", bad, 0);
        chk("R2", "ch0 still disabled level", int'(pwm_out[0]), 0);

        // R8 drive codes: active 1 (high), inactive 0 (float)
        bus_write(duty_addr(2), 2 << 16);
        bus_write(period_addr(2), per_word(4, 1, 0, 0));
        @(negedge clk);
        chk("R8", "float oe while disabled", int'(pwm_oe[2]), 0);
        bus_write(4, 4);
        bad = 0;
        for (int k = 0; k < 8; k++) begin
            if ((k % 4) < 2) begin
                if (pwm_oe[2] !== 1'b1 || pwm_out[2] !== 1'b1) bad++;
            end else begin
                if (pwm_oe[2] !== 1'b0) bad++;
            end
            @(negedge clk);
        end
        chk("R8", "drive pattern mismatches", bad, 0);
        chk("R2", "ch1 unaffected by set", int'(pwm_out[1]), 1);

        // R9 R10 largest prescaler on the last channel
        bus_write(duty_addr(3), 1 << 16);
        bus_write(period_addr(3), per_word(2, 3, 2, 7));
        bus_write(4, 8);
        run_len(3, 1'b1, 5000, n);
        chk("R9", "active run at ratio 1024", n, 1024);
        run_len(3, 1'b0, 5000, n);
        chk("R9", "inactive run at ratio 1024", n, 1024);

        finish_sim();
    end

endmodule